// File: doc/BRIEF.md
# Comparator Judgment Interrupt Controller

This block is the digital control for one analog comparator channel. Software programs a 16-bit mode register that picks an operating mode and an interrupt condition. The block then watches a comparator decision bit that has already been synchronized, together with measurement start and done strobes. From these it produces a one-clock interrupt pulse and a trigger-out level.

Three behaviours are available. In single mode, one judgment is made when a measurement completes. In single monitor mode, every completed measurement raises an interrupt. In supervisor mode, the decision bit is watched continuously from measurement start. The interrupt condition can be the level present at start, a later change of the decision, or both. The mode register is locked while the channel enable is high. Dropping the enable stops supervision and discards the edge history.

Top module: `cmp_judge_ctrl`

## Requirements
- R1: After reset, mode_o reads 16'h0000 and irq_o and trig_o are 0.
- R2: The mode register fields are as follows. The condition select is bits 1:0. The mode select is bits 5:4, where 00 means single, 01 means single monitor, 10 means supervisor and 11 is reserved. The sampling select is bits 9:8 and the clock select is bit 12. wr_lo_i loads bits 7:0 and wr_hi_i loads bits 15:8, so that both together form a word write. All other bits read as 0. mode_o shows a write from the cycle after the write edge.
- R3: A write presented while en_i is 1 leaves the mode register unchanged.
- R4: Single mode works as follows while en_i is 1. meas_done_i gives an irq_o pulse in the next cycle exactly when dec_i equals condition bit 1. Condition bit 0 has no effect.
- R5: In single monitor mode, every meas_done_i while en_i is 1 gives an irq_o pulse in the next cycle, whatever the values of dec_i and the condition bits.
- R6: In supervisor mode, condition 00 never raises irq_o.
- R7: In supervisor mode, meas_start_i while en_i is 1 raises one irq_o pulse in the next cycle when the start level matches. The level matches when dec_i is 0 for condition 01, or when dec_i is 1 for conditions 10 and 11. Holding that level afterwards gives no further pulse.
- R8: In supervisor mode, after a start, a change in dec_i between consecutive cycles raises irq_o in the next cycle. For condition 01 the change must be a fall, for 10 a rise, and for 11 either direction.
- R9: trig_o is 1 only in supervisor mode after a start, and it follows the registered decision. It is 1 when dec_i was 0 under condition 01, or when dec_i was 1 under condition 10 or 11. In every other case it is 0.
- R10: While en_i is 0, irq_o and trig_o stay 0 and supervision ends. After en_i returns to 1, changes in dec_i are ignored until a new meas_start_i.
- R11: The reserved mode code 11 behaves exactly like single mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Channel enable; locks the mode register |
| wr_lo_i | input | 1 | Write strobe for mode bits 7:0 |
| wr_hi_i | input | 1 | Write strobe for mode bits 15:8 |
| wdata_i | input | 16 | Write data |
| mode_o | output | 16 | Mode register readback |
| dec_i | input | 1 | Synchronized comparator decision |
| meas_start_i | input | 1 | Measurement start strobe |
| meas_done_i | input | 1 | Measurement done strobe |
| irq_o | output | 1 | One-clock interrupt pulse |
| trig_o | output | 1 | Trigger-out level |

## Verification
Every result is due one clock edge after the inputs that cause it. This holds for the interrupt pulse, the trigger level and the mode readback after a write. The bench drives each stimulus at the falling edge and computes the expected outputs from its own model of the requirements. It then samples one time unit after the next rising edge. Edge cases compare the decision presented in a cycle with the one presented in the cycle before, so every check lines up with exactly one rising edge.

// File: rtl/cmp_judge_pkg.sv
package cmp_judge_pkg;
  localparam int MODE_W = 16;
  localparam int BYTE_W = MODE_W / 2;
  localparam logic [BYTE_W-1:0] LO_MASK = 8'h33;
  localparam logic [BYTE_W-1:0] HI_MASK = 8'h13;

  typedef enum logic [1:0] {
    MD_SINGLE  = 2'b00,
    MD_MONITOR = 2'b01,
    MD_SUPER   = 2'b10,
    MD_RSVD    = 2'b11
  } cmp_mode_e;

  function automatic logic level_hit(input logic [1:0] cond, input logic d);
    case (cond)
      2'b01:        level_hit = ~d;
      2'b10, 2'b11: level_hit = d;
      default:      level_hit = 1'b0;
    endcase
  endfunction

  function automatic logic edge_hit(input logic [1:0] cond, input logic prev, input logic cur);
    case (cond)
      2'b01:   edge_hit = prev & ~cur;
      2'b10:   edge_hit = ~prev & cur;
      2'b11:   edge_hit = prev ^ cur;
      default: edge_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cmp_mode_reg.sv
module cmp_mode_reg
  import cmp_judge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [MODE_W-1:0] wdata_i,
  output logic [MODE_W-1:0] mode_o
);
  logic [MODE_W-1:0] mode_q;
  logic [1:0]        wr_byte;
  logic [MODE_W-1:0] mask;

  assign wr_byte = {wr_hi_i, wr_lo_i};
  assign mask    = {HI_MASK, LO_MASK};

  for (genvar b = 0; b < 2; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mode_q[b*BYTE_W +: BYTE_W] <= '0;
      else if (wr_byte[b] && !en_i)
        mode_q[b*BYTE_W +: BYTE_W] <= wdata_i[b*BYTE_W +: BYTE_W] & mask[b*BYTE_W +: BYTE_W];
    end
  end

  assign mode_o = mode_q;

  AST_WR_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> $stable(mode_o)); // R3
  AST_NO_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_lo_i || wr_hi_i) |=> $stable(mode_o)); // R2
endmodule

// File: rtl/cmp_event_det.sv
module cmp_event_det
  import cmp_judge_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  cmp_mode_e mode_i,
  input  logic [1:0] cond_i,
  input  logic      dec_i,
  input  logic      start_i,
  input  logic      done_i,
  output logic      irq_o,
  output logic      trig_o
);
  logic is_sup, is_mon;
  logic dec_q, active_q, irq_q, trig_q;
  logic irq_d, trig_d, active_d, lvl, edg;

  assign is_sup = (mode_i == MD_SUPER);
  assign is_mon = (mode_i == MD_MONITOR);
  assign lvl    = level_hit(cond_i, dec_i);
  assign edg    = active_q && !start_i && edge_hit(cond_i, dec_q, dec_i);

  always_comb begin
    irq_d    = 1'b0;
    trig_d   = 1'b0;
    active_d = 1'b0;
    if (en_i) begin
      if (is_sup) begin
        irq_d    = (start_i && lvl) || edg;
        active_d = start_i || active_q;
        trig_d   = active_d && lvl;
      end else if (is_mon) begin
        irq_d = done_i;
      end else begin
        irq_d = done_i && (dec_i == cond_i[1]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q    <= 1'b0;
      active_q <= 1'b0;
      irq_q    <= 1'b0;
      trig_q   <= 1'b0;
    end else begin
      dec_q    <= dec_i;
      active_q <= active_d;
      irq_q    <= irq_d;
      trig_q   <= trig_d;
    end
  end

  assign irq_o  = irq_q;
  assign trig_o = trig_q;

  AST_OFF_WHEN_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !irq_o && !trig_o); // R10
  AST_SUP_CODE0_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_sup && cond_i == 2'b00) |=> !irq_o); // R6
  AST_TRIG_ONLY_SUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_sup |=> !trig_o); // R9
  AST_MON_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mon && en_i) |=> (irq_o == $past(done_i))); // R5
  AST_SINGLE_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_sup && !is_mon && !done_i) |=> !irq_o); // R4
endmodule

// File: rtl/cmp_judge_ctrl.sv
module cmp_judge_ctrl
  import cmp_judge_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] mode_o,
  input  logic        dec_i,
  input  logic        meas_start_i,
  input  logic        meas_done_i,
  output logic        irq_o,
  output logic        trig_o
);
  logic [MODE_W-1:0] mode_q;
  cmp_mode_e         mode_sel;

  cmp_mode_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .wr_lo_i (wr_lo_i),
    .wr_hi_i (wr_hi_i),
    .wdata_i (wdata_i),
    .mode_o  (mode_q)
  );

  assign mode_sel = cmp_mode_e'(mode_q[5:4]);
  assign mode_o   = mode_q;

  cmp_event_det u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .mode_i  (mode_sel),
    .cond_i  (mode_q[1:0]),
    .dec_i   (dec_i),
    .start_i (meas_start_i),
    .done_i  (meas_done_i),
    .irq_o   (irq_o),
    .trig_o  (trig_o)
  );
endmodule

// File: tb/tb_cmp_judge_ctrl.sv
module tb_cmp_judge_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0, dec = 1'b0, st = 1'b0, dn = 1'b0;
  logic [15:0] wd = '0;
  logic [15:0] mode_o;
  logic irq, trig;
  int errors = 0, checks = 0;
  bit finished = 0;

  logic [15:0] m_mode = '0;
  logic m_act = 1'b0, m_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_judge_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wdata_i(wd), .mode_o(mode_o), .dec_i(dec), .meas_start_i(st),
    .meas_done_i(dn), .irq_o(irq), .trig_o(trig)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic start_match(input logic [1:0] c, input logic d);
    if (c == 2'b01) return !d;
    if (c == 2'b10 || c == 2'b11) return d;
    return 1'b0;
  endfunction

  function automatic logic change_match(input logic [1:0] c, input logic p, input logic d);
    case (c)
      2'b01: return (p == 1'b1) && (d == 1'b0);
      2'b10: return (p == 1'b0) && (d == 1'b1);
      2'b11: return p != d;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input logic e, input logic s, input logic f, input logic d,
                      input logic lo, input logic hi, input logic [15:0] w, input string tag);
    logic [1:0] md, c;
    logic e_irq, e_trig, lv;
    @(negedge clk);
    en = e; st = s; dn = f; dec = d; wr_lo = lo; wr_hi = hi; wd = w;
    md = m_mode[5:4]; c = m_mode[1:0];
    e_irq = 1'b0; e_trig = 1'b0;
    if (e) begin
      if (md == 2'b10) begin
        lv = start_match(c, d);
        if (s) e_irq = lv;
        else if (m_act) e_irq = change_match(c, m_prev, d);
        e_trig = (s || m_act) && lv;
      end else if (md == 2'b01) e_irq = f;
      else e_irq = f && (d == c[1]);
    end
    m_act  = e && (md == 2'b10) && (s || m_act);
    m_prev = d;
    if (!e) begin
      if (lo) m_mode[7:0]  = w[7:0] & 8'h33;
      if (hi) m_mode[15:8] = w[15:8] & 8'h13;
    end
    @(posedge clk); #1;
    chk(tag, "irq_o", {15'b0, irq}, {15'b0, e_irq});
    chk(tag, "trig_o", {15'b0, trig}, {15'b0, e_trig});
    chk(tag, "mode_o", mode_o, m_mode);
  endtask

  task automatic wr(input logic [15:0] w, input string tag);
    step(0, 0, 0, dec, 1, 1, w, tag);
  endtask
  task automatic run(input logic e, input logic s, input logic f, input logic d, input string tag);
    step(e, s, f, d, 0, 0, 16'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "mode_o", mode_o, 16'h0);
    chk("R1", "irq_o", {15'b0, irq}, 16'h0);
    chk("R1", "trig_o", {15'b0, trig}, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    // R2: byte writes and reserved bits
    step(0, 0, 0, 0, 1, 0, 16'hFFFF, "R2");
    step(0, 0, 0, 0, 0, 1, 16'hFFFF, "R2");
    chk("R2", "mode_word", mode_o, 16'h1333);
    wr(16'h0000, "R2");
    // R3: locked while enabled
    step(1, 0, 0, 0, 1, 1, 16'hFFFF, "R3");
    chk("R3", "locked", mode_o, 16'h0000);
    // R4: single, cond 10 then 01
    wr(16'h0002, "R4");
    run(1, 0, 1, 1, "R4"); run(1, 0, 1, 0, "R4"); run(1, 0, 0, 1, "R4");
    run(0, 0, 0, 0, "R4"); wr(16'h0001, "R4");
    run(1, 0, 1, 0, "R4"); run(1, 0, 1, 1, "R4");
    // R5: monitor
    run(0, 0, 0, 0, "R5"); wr(16'h0013, "R5");
    run(1, 0, 1, 0, "R5"); run(1, 0, 1, 1, "R5"); run(1, 1, 0, 1, "R5");
    // R6: supervisor code 00
    run(0, 0, 0, 0, "R6"); wr(16'h0020, "R6");
    run(1, 1, 0, 1, "R6"); run(1, 0, 0, 0, "R6"); run(1, 0, 0, 1, "R6");
    // R7: start level, code 10, held high
    run(0, 0, 0, 0, "R7"); wr(16'h0022, "R7");
    run(1, 1, 0, 1, "R7"); run(1, 0, 0, 1, "R7"); run(1, 0, 0, 1, "R7");
    // R8: edges under code 10, then 01 and 11
    run(1, 0, 0, 0, "R8"); run(1, 0, 0, 1, "R8");
    run(0, 0, 0, 0, "R8"); wr(16'h0021, "R8");
    run(1, 1, 0, 1, "R8"); run(1, 0, 0, 0, "R8"); run(1, 0, 0, 1, "R8");
    run(0, 0, 0, 0, "R8"); wr(16'h0023, "R8");
    run(1, 1, 0, 0, "R8"); run(1, 0, 0, 1, "R8"); run(1, 0, 0, 0, "R8");
    // R9: trig level tracking
    run(1, 0, 0, 1, "R9"); run(1, 0, 0, 1, "R9");
    chk("R9", "trig_high", {15'b0, trig}, 16'h1);
    // R10: disable clears history
    run(0, 0, 0, 0, "R10"); run(0, 1, 1, 1, "R10");
    run(1, 0, 0, 0, "R10"); run(1, 0, 0, 1, "R10");
    chk("R10", "no_edge_irq", {15'b0, irq}, 16'h0);
    run(1, 1, 0, 1, "R10");
    // R11: reserved mode acts as single
    run(0, 0, 0, 0, "R11"); wr(16'h0032, "R11");
    run(1, 0, 1, 1, "R11"); run(1, 0, 1, 0, "R11"); run(1, 1, 0, 1, "R11");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic e;
      string tag;
      e = ($urandom % 16) != 0;
      case (m_mode[5:4])
        2'b01: tag = "R5";
        2'b10: tag = "R8";
        2'b11: tag = "R11";
        default: tag = "R4";
      endcase
      if (!e && ($urandom % 2)) tag = "R3";
      step(e, ($urandom % 12) == 0, ($urandom % 5) == 0, ($urandom % 3) == 0 ? ~dec : dec,
           ($urandom % 3) == 0, ($urandom % 3) == 0, 16'($urandom), tag);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    finished = 1;
    $finish;
  end
endmodule